// File: doc/BRIEF.md
# Serial Configuration Target Responder

This block sits on the target side of a four-wire serial configuration link. It stands in for a device whose configuration port is loaded by a host controller. Each chip-select-low period is one frame. The first byte is an opcode and three padding bytes follow it. The block acts on the opcode once the fourth byte is complete. For identification and status queries it shifts a 32-bit answer back in the bytes that come after the padding.

Beside the link, the block keeps a small configuration state: whether writes are allowed, whether the array is being wiped or has been wiped, how many image bytes have streamed in, and whether loading has finished. The identification word, the expected image length and the length of the wipe are parameters. The state is brought out on debug pins so that a system model or a test can watch a load sequence step by step. No configuration array is stored, and the image contents are not checked.

The link uses mode 0. Both sides sample on the rising SCK edge. The block updates MISO after each rising edge and takes MOSI most significant bit first. All link pins are sampled by the block clock, so SCK must be several times slower than that clock.

Top module: `cfg_port_responder`

## Requirements
- R1: A command acts only when the fourth byte of its frame (opcode plus three padding bytes) is complete. A frame that ends with chip select high before then changes no state.
- R2: After opcode 0x07 and its padding, the next four bytes on MISO carry the DEV_ID parameter, most significant bit first.
- R3: After opcode 0x09 and its padding, the next four bytes on MISO carry the status word. Bit 16 is the wiped flag and bit 14 is the loaded (done) flag. All other bits are 0.
- R4: Opcode 0x70 starts a wipe and clears the loaded flag and the byte count. While the wipe runs, the status word reads 0. After CLEAR_CYCLES clock cycles the wiped flag sets and the status word reads 0x00010000.
- R5: Opcode 0x4A sets the write-enable flag and opcode 0x4F clears it.
- R6: In an opcode 0x41 frame, every byte after the padding adds one to the byte count while write-enable is set, until chip select rises. While write-enable is clear, such bytes leave the count unchanged.
- R7: Opcode 0x4F sets the loaded flag when the byte count is at least IMAGE_BYTES, and leaves it clear otherwise.
- R8: Opcode 0x71 clears the loaded, wiped and write-enable flags and the byte count, and cancels a wipe in progress, so the wiped flag stays clear.
- R9: Any other opcode changes no state and is answered with 0x00 bytes. MISO is 0 while chip select is high and after the four answer bytes.
- R10: After reset, all debug outputs and MISO are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host-to-target data |
| spi_miso | output | 1 | Target-to-host data |
| dbg_wr_en | output | 1 | Write-enable flag |
| dbg_clearing | output | 1 | Wipe in progress |
| dbg_cleared | output | 1 | Wiped flag |
| dbg_done | output | 1 | Loaded flag |
| dbg_data_bytes | output | CNT_W | Image bytes accepted since the last wipe or refresh |

## Verification
The bench builds the block with IMAGE_BYTES set to 5 and CLEAR_CYCLES set to 1000. A five-byte image can be streamed in two short write frames, so both sides of the done threshold are reached: three bytes fall short and five bytes meet it. A 1000-cycle wipe outlasts a complete status frame sent right after the clear command, so the all-zero status during the wipe is observed before the wiped value. The identification word is set to a non-default value so that the ID answer is checked against the parameter.

// File: rtl/cfg_port_responder.sv
module cfg_port_responder #(
  parameter logic [31:0] DEV_ID       = 32'hA5C3_0F1E,
  parameter int          IMAGE_BYTES  = 16,
  parameter int          CLEAR_CYCLES = 200,
  parameter int          CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             dbg_wr_en,
  output logic             dbg_clearing,
  output logic             dbg_cleared,
  output logic             dbg_done,
  output logic [CNT_W-1:0] dbg_data_bytes
);
  localparam int TW = $clog2(CLEAR_CYCLES + 2);
  localparam logic [7:0] OP_ID    = 8'h07;
  localparam logic [7:0] OP_STAT  = 8'h09;
  localparam logic [7:0] OP_CLEAR = 8'h70;
  localparam logic [7:0] OP_RFSH  = 8'h71;
  localparam logic [7:0] OP_WEN   = 8'h4A;
  localparam logic [7:0] OP_WDIS  = 8'h4F;
  localparam logic [7:0] OP_WINC  = 8'h41;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sck_s, sck_p, cs_s, mosi_s;
  logic [2:0] bit_cnt;
  logic [3:0] byte_idx;
  logic [6:0] shreg;
  logic [7:0] opcode;
  logic [31:0] resp;
  logic [TW-1:0] timer;

  wire       rise      = sck_s & ~sck_p & ~cs_s;
  wire       last_bit  = rise && (bit_cnt == 3'd7);
  wire [7:0] rx_byte   = {shreg, mosi_s};
  wire       exec      = last_bit && (byte_idx == 4'd3);
  wire       data_byte = last_bit && (byte_idx >= 4'd4) && (opcode == OP_WINC) && dbg_wr_en;
  wire [31:0] status   = {15'd0, dbg_cleared, 1'b0, dbg_done, 14'd0};

  assign spi_miso = ~cs_s & resp[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 1'b0;
      sck_p  <= 1'b0;
      cs_s   <= 1'b1;
      mosi_s <= 1'b0;
    end else begin
      sck_s  <= spi_sck;
      sck_p  <= sck_s;
      cs_s   <= spi_cs_n;
      mosi_s <= spi_mosi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      opcode   <= '0;
      resp     <= '0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      resp     <= '0;
    end else if (rise) begin
      shreg   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (last_bit && byte_idx != 4'd8) byte_idx <= byte_idx + 4'd1;
      if (last_bit && byte_idx == 4'd0) opcode <= rx_byte;
      if (exec)
        resp <= (opcode == OP_ID) ? DEV_ID : (opcode == OP_STAT) ? status : 32'd0;
      else if (byte_idx >= 4'd4)
        resp <= {resp[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_wr_en      <= 1'b0;
      dbg_clearing   <= 1'b0;
      dbg_cleared    <= 1'b0;
      dbg_done       <= 1'b0;
      dbg_data_bytes <= '0;
      timer          <= '0;
    end else if (exec) begin
      case (opcode)
        OP_CLEAR: begin
          dbg_clearing   <= 1'b1;
          dbg_cleared    <= 1'b0;
          dbg_done       <= 1'b0;
          dbg_data_bytes <= '0;
          timer          <= TW'(CLEAR_CYCLES);
        end
        OP_RFSH: begin
          dbg_clearing   <= 1'b0;
          dbg_cleared    <= 1'b0;
          dbg_done       <= 1'b0;
          dbg_wr_en      <= 1'b0;
          dbg_data_bytes <= '0;
        end
        OP_WEN:  dbg_wr_en <= 1'b1;
        OP_WDIS: begin
          dbg_wr_en <= 1'b0;
          if (dbg_data_bytes >= CNT_W'(IMAGE_BYTES)) dbg_done <= 1'b1;
        end
        default: ;
      endcase
    end else begin
      if (dbg_clearing) begin
        if (timer <= TW'(1)) begin
          dbg_clearing <= 1'b0;
          dbg_cleared  <= 1'b1;
        end else begin
          timer <= timer - TW'(1);
        end
      end
      if (data_byte && dbg_data_bytes != CNT_MAX)
        dbg_data_bytes <= dbg_data_bytes + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cfg_port_responder_chk.sv
module cfg_port_responder_chk #(
  parameter int IMAGE_BYTES = 16,
  parameter int CNT_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             dbg_wr_en,
  input logic             dbg_clearing,
  input logic             dbg_cleared,
  input logic             dbg_done,
  input logic [CNT_W-1:0] dbg_data_bytes
);
  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_data_bytes != $past(dbg_data_bytes)) |->
      (dbg_data_bytes == $past(dbg_data_bytes) + CNT_W'(1) || dbg_data_bytes == '0));
  // R6
  count_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_data_bytes == $past(dbg_data_bytes) + CNT_W'(1)) |-> $past(dbg_wr_en));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_done) |-> ($past(dbg_data_bytes) >= CNT_W'(IMAGE_BYTES) && !dbg_wr_en));
  // R4
  clear_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_cleared) |-> $past(dbg_clearing));
  // R4
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_clearing && dbg_cleared));
endmodule

bind cfg_port_responder cfg_port_responder_chk #(
  .IMAGE_BYTES(IMAGE_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .dbg_wr_en(dbg_wr_en), .dbg_clearing(dbg_clearing), .dbg_cleared(dbg_cleared),
  .dbg_done(dbg_done), .dbg_data_bytes(dbg_data_bytes)
);

// File: tb/sim_cfg_port_responder.sv
`timescale 1ns/1ps
module sim_cfg_port_responder;
  localparam logic [31:0] ID = 32'h5EC0_3A71;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_en, clearing, cleared, done;
  logic [CW-1:0] nbytes;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_port_responder #(.DEV_ID(ID), .IMAGE_BYTES(5), .CLEAR_CYCLES(1000), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .dbg_wr_en(wr_en), .dbg_clearing(clearing), .dbg_cleared(cleared),
    .dbg_done(done), .dbg_data_bytes(nbytes));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nx, input logic [7:0] fill,
                       output logic [31:0] w0, output logic [31:0] w1);
    logic [7:0] r;
    w0 = '0; w1 = '0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xbyte(op, r);
    for (int p = 0; p < 3; p++) xbyte(8'h00, r);
    for (int k = 0; k < nx; k++) begin
      xbyte(fill, r);
      if (k < 4) w0 = {w0[23:0], r};
      else if (k < 8) w1 = {w1[23:0], r};
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [31:0] a, b;
    frame(op, 0, 8'h00, a, b);
  endtask

  task automatic rd_status(output logic [31:0] s);
    logic [31:0] b;
    frame(8'h09, 4, 8'h00, s, b);
  endtask

  task automatic t_reset();
    chk("R10 flags", {27'd0, miso, wr_en, clearing, cleared, done}, 32'd0);
    chk("R10 count", 32'(nbytes), 32'd0);
  endtask

  task automatic t_id();
    logic [31:0] a, b;
    frame(8'h07, 8, 8'h00, a, b);
    chk("R2 id word", a, ID);
    chk("R9 after answer", b, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] s;
    rd_status(s);
    chk("R3 status before clear", s, 32'd0);
    cmd(8'h70);
    rd_status(s);
    chk("R4 status while clearing", s, 32'd0);
    chk("R4 clearing flag", 32'(clearing), 32'd1);
    repeat (1100) @(negedge clk);
    rd_status(s);
    chk("R4 status cleared", s, 32'h0001_0000);
  endtask

  task automatic t_write();
    logic [31:0] a, b, s;
    frame(8'h41, 3, 8'hC3, a, b);
    chk("R6 ignored when disabled", 32'(nbytes), 32'd0);
    cmd(8'h4A);
    chk("R5 write enable", 32'(wr_en), 32'd1);
    frame(8'h41, 3, 8'h96, a, b);
    chk("R6 three bytes", 32'(nbytes), 32'd3);
    cmd(8'h4F);
    chk("R5 write disable", 32'(wr_en), 32'd0);
    chk("R7 short image not done", 32'(done), 32'd0);
    cmd(8'h4A);
    frame(8'h41, 2, 8'h3C, a, b);
    chk("R6 five bytes", 32'(nbytes), 32'd5);
    cmd(8'h4F);
    chk("R7 done at threshold", 32'(done), 32'd1);
    rd_status(s);
    chk("R3 status done", s, 32'h0001_4000);
  endtask

  task automatic t_short_unknown();
    logic [31:0] a, b;
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xbyte(8'h71, r);
    xbyte(8'h00, r);
    xbyte(8'h00, r);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 truncated refresh", {29'd0, done, cleared, wr_en}, 32'd6);
    frame(8'h55, 4, 8'hFF, a, b);
    chk("R9 unknown answer", a, 32'd0);
    chk("R9 unknown no change", {29'd0, done, cleared, wr_en}, 32'd6);
    chk("R9 idle miso", 32'(miso), 32'd0);
  endtask

  task automatic t_refresh();
    cmd(8'h4A);
    cmd(8'h71);
    chk("R8 refresh flags", {28'd0, done, cleared, wr_en, clearing}, 32'd0);
    chk("R8 refresh count", 32'(nbytes), 32'd0);
    cmd(8'h70);
    chk("R8 clear started", 32'(clearing), 32'd1);
    cmd(8'h71);
    repeat (1100) @(negedge clk);
    chk("R8 clear cancelled", {30'd0, cleared, clearing}, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_id();
    t_clear();
    t_write();
    t_short_unknown();
    t_refresh();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule